// File: doc/BRIEF.md
# Read-After-Read Settling Interlock

This block sits between a host CPU request port and a synchronous peripheral register bus. Some peripheral registers have side effects when read, such as popping a FIFO or clearing a counter. After such a read, certain other registers take a short while to show the new state. If the host reads one of those registers too early, it gets stale data. The interlock remembers when each side-effect register was last read on the bus. It holds back a later read whose target has not yet settled, for as many bus cycles as that pair of registers needs.

Each settling time is stored in nanoseconds. The number of cycles to hold back is that time divided by the `CYCLE_NS` parameter, rounded up. The wait can be filled in one of two ways, chosen by `cfg_fill_probe`. Either the interlock issues harmless reads of a probe register, whose data is thrown away, or the bus is left idle. Host reads of other registers made in the meantime also count toward the wait. Writes go straight through and are never checked. Pairs that are not in the settling table add no latency.

Top module: `rar_interlock`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `bus_rd`, `bus_wr` and `rsp_valid` are 0. With no earlier reads, `req_ready` is 1.
- R2: Let N = ceil(135 / CYCLE_NS), which is 3 at 45 ns. A bus read of the receive FIFO information register (0x1E) must come at least N+1 cycles after the last bus read of the receive data FIFO (0x00) or of the receive status FIFO (0x10). A bus read of the transmit FIFO information register (0x1F) must come at least N+1 cycles after the last bus read of the transmit status FIFO (0x11). When the later read is issued back to back, the spacing is exactly N+1.
- R3: Two bus reads of the drop counter (0x28) are at least ceil(180 / CYCLE_NS)+1 cycles apart, which is 5 at 45 ns.
- R4: When `req_csr_step` is 1 as the later read is accepted, a read of the switch command register (0x2A) comes at least ceil(45 / CYCLE_NS)+1 cycles after the last read of the switch data register (0x2B). When it is 0, there is no added gap.
- R5: Two bus reads of the auto-negotiation expansion register (0x31) are at least ceil(45 / CYCLE_NS)+1 cycles apart.
- R6: A read whose address pair is not in the table is put on the bus in the cycle after the previous read. No latency is added.
- R7: If `cfg_fill_probe` is 1, every cycle in which a read is held back carries a bus read of the probe register (0x19), so a gap of N cycles holds exactly N probe reads. If it is 0, the bus stays idle during a gap.
- R8: Each accepted host read gives exactly one `rsp_valid` pulse, two cycles after its bus strobe, in order, carrying the `bus_rdata` of that strobe. Probe reads never produce a response.
- R9: Each side-effect register has its own elapsed-cycle count, counted from its last bus read. Bus reads of other registers made in between count toward the gap and do not restart it.
- R10: A write is accepted at once and appears on `bus_wr` in the next cycle with its address and data, whatever the hazard state. `bus_rd` and `bus_wr` are never high together.
- R11: An accepted request appears on the bus in the next cycle with its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fill_probe | input | 1 | 1: fill gaps with probe reads; 0: fill gaps with idle cycles |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted this cycle when high together with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| req_csr_step | input | 1 | Switch register access is in auto-increment or auto-decrement mode |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | DATA_W | Read data returned to the host |
| bus_rd | output | 1 | Peripheral read strobe |
| bus_wr | output | 1 | Peripheral write strobe |
| bus_addr | output | ADDR_W | Peripheral address |
| bus_wdata | output | DATA_W | Peripheral write data |
| bus_rdata | input | DATA_W | Peripheral read data, valid the cycle after `bus_rd` |

## Verification
Some properties are checked on every cycle. For every listed pair, the dependent read never follows its source read in the next cycle. Probe strobes only occur when probe filling was selected. A response always trails a host bus read by exactly two cycles. An accepted request always reaches the bus on the next cycle with its own address. Other behaviour can only be shown by the bench's scenarios: that each gap is exactly N+1 cycles and not longer, that unlisted pairs see no added latency, that reads in between are credited to the gap, and that returned data matches in order.

// File: rtl/rar_pkg.sv
`timescale 1ns/1ps
package rar_pkg;
  localparam int NSRC = 6;

  // register word addresses
  localparam int A_RXDATA  = 'h00;
  localparam int A_RXSTAT  = 'h10;
  localparam int A_TXSTAT  = 'h11;
  localparam int A_PROBE   = 'h19;
  localparam int A_RXINFO  = 'h1E;
  localparam int A_TXINFO  = 'h1F;
  localparam int A_DROP    = 'h28;
  localparam int A_CSRCMD  = 'h2A;
  localparam int A_CSRDATA = 'h2B;
  localparam int A_ANEXP   = 'h31;

  localparam int MAX_GAP_NS = 180;

  // address of the side-effect register tracked by slot s
  function automatic int src_addr(int s);
    case (s)
      0:       return A_RXDATA;
      1:       return A_RXSTAT;
      2:       return A_TXSTAT;
      3:       return A_DROP;
      4:       return A_CSRDATA;
      default: return A_ANEXP;
    endcase
  endfunction

  // settling time in ns for (slot s read earlier, tgt read later)
  function automatic int gap_ns(int s, int tgt, logic step);
    int g;
    g = 0;
    case (s)
      0, 1:    if (tgt == A_RXINFO) g = 135;
      2:       if (tgt == A_TXINFO) g = 135;
      3:       if (tgt == A_DROP) g = 180;
      4:       if (tgt == A_CSRCMD && step) g = 45;
      default: if (tgt == A_ANEXP) g = 45;
    endcase
    return g;
  endfunction

  function automatic int ns_to_cyc(int ns, int per);
    return (ns + per - 1) / per;
  endfunction
endpackage

// File: rtl/rar_age.sv
`timescale 1ns/1ps
module rar_age #(
  parameter int AGE_W = 3,
  parameter int MAXV  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  output logic [AGE_W-1:0] elapsed
);
  logic [AGE_W-1:0] age_q;

  // saturating count of cycles since the last bus read of this slot
  always_ff @(posedge clk) begin
    if (rst)                         age_q <= AGE_W'(MAXV);
    else if (hit)                    age_q <= AGE_W'(1);
    else if (age_q != AGE_W'(MAXV))  age_q <= age_q + 1'b1;
  end

  // a read on the bus right now counts as zero elapsed cycles
  assign elapsed = hit ? '0 : age_q;

  assert_age_range_R9: assert property (@(posedge clk) disable iff (rst)
    (age_q != '0) && (age_q <= AGE_W'(MAXV)));
  assert_age_restart_R9: assert property (@(posedge clk) disable iff (rst)
    hit |=> (age_q == AGE_W'(1)));
endmodule

// File: rtl/rar_gap_check.sv
`timescale 1ns/1ps
module rar_gap_check
  import rar_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int AGE_W    = 3,
  parameter int CYCLE_NS = 45
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        step,
  input  logic [NSRC-1:0][AGE_W-1:0]  elapsed,
  output logic                        blocked
);
  logic [NSRC-1:0]             blk;
  logic [NSRC-1:0][AGE_W-1:0]  need;

  for (genvar s = 0; s < NSRC; s++) begin : g_slot
    assign need[s] = AGE_W'(ns_to_cyc(gap_ns(s, int'(addr), step), CYCLE_NS));
    assign blk[s]  = elapsed[s] < need[s];
  end

  assign blocked = |blk;
endmodule

// File: rtl/rar_interlock.sv
`timescale 1ns/1ps
module rar_interlock
  import rar_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CYCLE_NS = 45
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_fill_probe,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_csr_step,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int MAXC  = ns_to_cyc(MAX_GAP_NS, CYCLE_NS);
  localparam int AGE_W = (MAXC < 1) ? 1 : $clog2(MAXC + 1);

  logic [NSRC-1:0][AGE_W-1:0] elapsed;
  logic [NSRC-1:0]            hit;
  logic blocked, accept, hold_rd;
  logic host_q, host_q2;

  for (genvar s = 0; s < NSRC; s++) begin : g_age
    assign hit[s] = bus_rd && (bus_addr == ADDR_W'(src_addr(s)));
    rar_age #(.AGE_W(AGE_W), .MAXV(MAXC)) u_age (
      .clk(clk), .rst(rst), .hit(hit[s]), .elapsed(elapsed[s]));
  end

  rar_gap_check #(.ADDR_W(ADDR_W), .AGE_W(AGE_W), .CYCLE_NS(CYCLE_NS)) u_gap (
    .addr(req_addr), .step(req_csr_step), .elapsed(elapsed), .blocked(blocked));

  assign req_ready = req_write || !blocked;
  assign accept    = req_valid && req_ready;
  assign hold_rd   = req_valid && !req_write && blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      host_q    <= 1'b0;
      host_q2   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      bus_rd    <= (accept && !req_write) || (hold_rd && cfg_fill_probe);
      bus_wr    <= accept && req_write;
      bus_addr  <= accept ? req_addr : ADDR_W'(A_PROBE);
      bus_wdata <= req_wdata;
      host_q    <= accept && !req_write;
      host_q2   <= bus_rd && host_q;
      rsp_valid <= host_q2;
      rsp_data  <= bus_rdata;
    end
  end

  assert_rxinfo_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == ADDR_W'(A_RXDATA) || bus_addr == ADDR_W'(A_RXSTAT)))
      |=> !(bus_rd && bus_addr == ADDR_W'(A_RXINFO)));
  assert_txinfo_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(A_TXSTAT)) |=> !(bus_rd && bus_addr == ADDR_W'(A_TXINFO)));
  assert_drop_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(A_DROP)) |=> !(bus_rd && bus_addr == ADDR_W'(A_DROP)));
  assert_csr_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(A_CSRDATA) && req_csr_step)
      |=> !(bus_rd && bus_addr == ADDR_W'(A_CSRCMD)));
  assert_anexp_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(A_ANEXP)) |=> !(bus_rd && bus_addr == ADDR_W'(A_ANEXP)));
  assert_probe_mode_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !host_q) |-> $past(cfg_fill_probe));
  assert_rsp_timing_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(bus_rd && host_q, 2));
  assert_one_op_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
  assert_issue_R11: assert property (@(posedge clk) disable iff (rst)
    accept |=> ((bus_rd || bus_wr) && bus_addr == $past(req_addr)));
endmodule

// File: tb/sim_rar_interlock.sv
`timescale 1ns/1ps
module sim_rar_interlock;
  import rar_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_fill_probe = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic       req_csr_step = 1'b1;
  logic       rsp_valid;
  logic [31:0] rsp_data;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;

  always #2.5 clk = ~clk;

  rar_interlock #(.ADDR_W(8), .DATA_W(32), .CYCLE_NS(45)) u0 (
    .clk(clk), .rst(rst), .cfg_fill_probe(cfg_fill_probe),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_csr_step(req_csr_step),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  // peripheral model: data carries the address it came from
  always @(posedge clk) if (bus_rd) bus_rdata <= {24'hD00D00, bus_addr};

  int checks = 0, fails = 0;
  int cyc = 0, probes = 0, host_reads = 0, rsps = 0;
  int wr_cyc = -1;
  int wr_addr = -1;
  logic [31:0] wr_data = '0;
  int log_cyc[$];
  logic [31:0] expq[$];
  int srcs[6] = '{'h00, 'h10, 'h11, 'h28, 'h2B, 'h31};
  int last_src[6] = '{-1000, -1000, -1000, -1000, -1000, -1000};

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // required idle cycles from the requirements, 45 ns bus cycle
  function automatic int bgap(int s, int t, bit step);
    if ((s == 'h00 || s == 'h10) && t == 'h1E) return 3;
    if (s == 'h11 && t == 'h1F) return 3;
    if (s == 'h28 && t == 'h28) return 4;
    if (s == 'h2B && t == 'h2A) return step ? 1 : 0;
    if (s == 'h31 && t == 'h31) return 1;
    return 0;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst && bus_wr) begin
      wr_cyc = cyc; wr_addr = int'(bus_addr); wr_data = bus_wdata;
    end
    if (!rst && bus_rd) begin
      if (bus_addr == 8'h19) probes++;
      else begin
        for (int s = 0; s < 6; s++) begin
          int need;
          need = bgap(srcs[s], int'(bus_addr), req_csr_step);
          if (need > 0)
            chk(cyc - last_src[s] >= need + 1, "R9 min spacing", cyc - last_src[s], need + 1);
        end
        for (int s = 0; s < 6; s++) if (int'(bus_addr) == srcs[s]) last_src[s] = cyc;
        log_cyc.push_back(cyc);
        expq.push_back({24'hD00D00, bus_addr});
        host_reads++;
      end
    end
    if (!rst && rsp_valid) begin
      logic [31:0] e;
      rsps++;
      e = (expq.size() > 0) ? expq.pop_front() : 32'hFFFFFFFF;
      chk(rsp_data == e, "R8 response data", int'(rsp_data), int'(e));
    end
  end

  task automatic issue(bit w, logic [7:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    req_valid = 1'b0; req_write = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pair(logic [7:0] a, logic [7:0] b, int n, string tag);
    int i0, p0, sp;
    idle(6);
    i0 = log_cyc.size(); p0 = probes;
    issue(1'b0, a, '0);
    issue(1'b0, b, '0);
    idle(4);
    chk(log_cyc.size() == i0 + 2, tag, log_cyc.size() - i0, 2);
    if (log_cyc.size() == i0 + 2) begin
      sp = log_cyc[i0 + 1] - log_cyc[i0];
      chk(sp == n + 1, tag, sp, n + 1);
    end
    chk(probes - p0 == (cfg_fill_probe ? n : 0), "R7 gap fill", probes - p0,
        cfg_fill_probe ? n : 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int i0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!bus_rd && !bus_wr && !rsp_valid, "R1 outputs in reset", int'({bus_rd, bus_wr, rsp_valid}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_rd && !bus_wr && !rsp_valid, "R1 outputs after reset", int'({bus_rd, bus_wr, rsp_valid}), 0);
    req_addr = 8'h1E; #1;
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    for (int m = 1; m >= 0; m--) begin
      cfg_fill_probe = m[0];
      req_csr_step = 1'b1;
      pair(8'h00, 8'h1E, 3, "R2 rxdata->rxinfo");
      pair(8'h10, 8'h1E, 3, "R2 rxstat->rxinfo");
      pair(8'h11, 8'h1F, 3, "R2 txstat->txinfo");
      pair(8'h28, 8'h28, 4, "R3 drop->drop");
      pair(8'h2B, 8'h2A, 1, "R4 csrdata->csrcmd step");
      pair(8'h31, 8'h31, 1, "R5 anexp->anexp");
      pair(8'h00, 8'h1F, 0, "R6 rxdata->txinfo");
      pair(8'h11, 8'h1E, 0, "R6 txstat->rxinfo");
      pair(8'h1E, 8'h00, 0, "R6 rxinfo->rxdata");
      req_csr_step = 1'b0;
      idle(2);
      pair(8'h2B, 8'h2A, 0, "R4 csrdata->csrcmd no step");
      req_csr_step = 1'b1;
    end

    // R9: an unrelated read in between is credited to the gap
    cfg_fill_probe = 1'b1;
    idle(6);
    i0 = log_cyc.size();
    issue(1'b0, 8'h00, '0); issue(1'b0, 8'h05, '0); issue(1'b0, 8'h1E, '0);
    idle(4);
    if (log_cyc.size() == i0 + 3) begin
      chk(log_cyc[i0 + 2] - log_cyc[i0] == 4, "R9 credited", log_cyc[i0 + 2] - log_cyc[i0], 4);
      chk(log_cyc[i0 + 1] - log_cyc[i0] == 1, "R6 unrelated no delay", log_cyc[i0 + 1] - log_cyc[i0], 1);
    end else chk(0, "R9 read count", log_cyc.size() - i0, 3);

    // R9: independent slots
    idle(6);
    i0 = log_cyc.size();
    issue(1'b0, 8'h00, '0); issue(1'b0, 8'h11, '0);
    issue(1'b0, 8'h1E, '0); issue(1'b0, 8'h1F, '0);
    idle(4);
    if (log_cyc.size() == i0 + 4) begin
      chk(log_cyc[i0 + 2] - log_cyc[i0] == 4, "R9 rx slot", log_cyc[i0 + 2] - log_cyc[i0], 4);
      chk(log_cyc[i0 + 3] - log_cyc[i0 + 1] == 4, "R9 tx slot", log_cyc[i0 + 3] - log_cyc[i0 + 1], 4);
    end else chk(0, "R9 read count", log_cyc.size() - i0, 4);

    // R10/R11: write passes through during a pending hazard
    idle(6);
    i0 = log_cyc.size();
    issue(1'b0, 8'h00, '0);
    issue(1'b1, 8'h1E, 32'hCAFE0123);
    issue(1'b0, 8'h1E, '0);
    idle(4);
    chk(wr_cyc - log_cyc[i0] == 1, "R10 write not stalled", wr_cyc - log_cyc[i0], 1);
    chk(wr_addr == 'h1E && wr_data == 32'hCAFE0123, "R10 write fields", wr_addr, 'h1E);
    if (log_cyc.size() == i0 + 2)
      chk(log_cyc[i0 + 1] - log_cyc[i0] == 4, "R2 read after write", log_cyc[i0 + 1] - log_cyc[i0], 4);
    else chk(0, "R11 read count", log_cyc.size() - i0, 2);

    // random traffic
    for (int k = 0; k < 400; k++) begin
      logic [7:0] pool[11];
      pool = '{8'h00, 8'h10, 8'h11, 8'h1E, 8'h1F, 8'h28, 8'h2A, 8'h2B, 8'h31, 8'h05, 8'h40};
      if (k % 100 == 0) begin
        idle(6);
        cfg_fill_probe = 1'($urandom_range(0, 1));
        req_csr_step = 1'($urandom_range(0, 1));
      end
      issue($urandom_range(0, 5) == 0, pool[$urandom_range(0, 10)], $urandom());
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 2));
    end
    idle(8);
    chk(rsps == host_reads, "R8 one response per host read", rsps, host_reads);
    chk(expq.size() == 0, "R8 no probe responses", expq.size(), 0);
    summary();
    $finish;
  end
endmodule